// File: doc/BRIEF.md
# Two-bit hardware cursor overlay

This block lays a small hardware cursor over the live pixel stream. Each clock the display timing supplies the coordinates of the pixel being produced. The block compares them with a packed cursor position word and a packed cursor base/height word. Inside the cursor rectangle it fetches the pixel's two-bit code from an internal image RAM. The code goes to the palette stage downstream, where code 0 means transparent.

The cursor is always 64 pixels wide and has no separate mask plane. Its height comes from a six-bit field. Every image row takes sixteen bytes, which is four 32-bit RAM words of sixteen pixels each. The host fills the RAM through a simple word write port. The RAM read address is formed from the incoming coordinates in the same cycle they arrive, so the code leaves the block exactly one clock after its pixel.

Top module: `cursor_overlay`

## Requirements
- R1: The position input carries the cursor column in bits [11:0] and the cursor row in bits [23:12].
- R2: A pixel is horizontally inside when its column x satisfies cx <= x <= cx+63, compared without wrap-around, so columns below cx, including column 0 when cx sits near 4095, are outside.
- R3: The base input carries the height h in bits [15:10]. A pixel is vertically inside when cy <= y < cy+h, and h = 0 shows no rows.
- R4: Bit 2 of the control input enables the cursor. While it is 0 the output code is 0, and the other control bits have no effect.
- R5: Outside the cursor rectangle the output code is 0.
- R6: For an inside pixel the RAM word is (base[9:2] + 4*(y-cy) + (x-cx)/16) modulo 256. Base bits [1:0] are ignored.
- R7: Within a word, cursor pixel k = (x-cx) mod 16 occupies bits [2k+1:2k].
- R8: The code for a pixel presented at clock edge n appears on the output after edge n+1, with exactly one cycle of latency.
- R9: While reset is asserted, the output code reads 0 after each clock edge.
- R10: When the write enable is high at a clock edge, the 32-bit write data is stored at the 8-bit word address given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_x | input | 12 | Column of the current pixel |
| pix_y | input | 12 | Row of the current pixel |
| cur_pos | input | 24 | Packed cursor position: row [23:12], column [11:0] |
| cur_base | input | 16 | Height [15:10], image byte offset [9:0] |
| vid_ctrl | input | 8 | Video control bits; bit 2 enables the cursor |
| ram_we | input | 1 | Image RAM write enable |
| ram_waddr | input | 8 | Image RAM word address |
| ram_wdata | input | 32 | Image RAM write word, sixteen 2-bit pixels |
| cur_code | output | 2 | Cursor code for the pixel of the previous cycle; 0 is transparent |

## Verification
The assertions check a set of gating rules on every cycle. A non-zero code needs the enable bit and both window conditions to have held one cycle earlier, a zero height keeps the output at zero, and reset forces the code to zero. Only the bench scenarios can show that the code is the correct one. This covers the RAM address arithmetic, including wrap-around of the word address and the ignored low base bits, the pixel order within a word, and the exact one-cycle alignment against the swept pixel stream.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CW = 12,
  parameter int HW = 6,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   pix_x,
  input  logic [CW-1:0]   pix_y,
  input  logic [2*CW-1:0] cur_pos,
  input  logic [HW+9:0]   cur_base,
  input  logic [7:0]      vid_ctrl,
  input  logic            ram_we,
  input  logic [AW-1:0]   ram_waddr,
  input  logic [DW-1:0]   ram_wdata,
  output logic [1:0]      cur_code
);
  localparam int CUR_W = 64;
  localparam int PPW   = DW / 2;
  localparam int SW    = $clog2(PPW);
  localparam int XW    = $clog2(CUR_W);
  localparam int WSW   = XW - SW;
  localparam int BB    = $clog2(DW / 8);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [SW-1:0] sel_q;
  logic          in_q;

  logic [CW:0]   dx, dy;
  logic          in_x, in_y;
  logic [AW-1:0] rd_addr;
  logic [HW-1:0] height;

  assign height = cur_base[HW+9:10];
  assign dx = {1'b0, pix_x} - {1'b0, cur_pos[CW-1:0]};
  assign dy = {1'b0, pix_y} - {1'b0, cur_pos[2*CW-1:CW]};
  assign in_x = !dx[CW] && (dx[CW-1:0] < CW'(CUR_W));
  assign in_y = !dy[CW] && (dy[CW-1:0] < CW'(height));

  assign rd_addr = AW'(cur_base[9:BB])
                 + AW'({dy[HW-1:0], {WSW{1'b0}}})
                 + AW'(dx[XW-1:SW]);

  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_waddr] <= ram_wdata;
    rd_q <= mem[rd_addr];
    sel_q <= dx[SW-1:0];
    if (rst) in_q <= 1'b0;
    else     in_q <= in_x && in_y && vid_ctrl[2];
  end

  assign cur_code = in_q ? rd_q[{sel_q, 1'b0} +: 2] : 2'b00;

  logic unused_bits;
  assign unused_bits = ^{cur_base[BB-1:0], vid_ctrl[7:3], vid_ctrl[1:0]};
endmodule

module cursor_overlay_chk #(
  parameter int CW = 12,
  parameter int HW = 6
) (
  input logic            clk,
  input logic            rst,
  input logic [CW-1:0]   pix_x,
  input logic [CW-1:0]   pix_y,
  input logic [2*CW-1:0] cur_pos,
  input logic [HW+9:0]   cur_base,
  input logic [7:0]      vid_ctrl,
  input logic [1:0]      cur_code
);
  logic x_ok, y_ok;
  assign x_ok = (pix_x >= cur_pos[CW-1:0]) && ((pix_x - cur_pos[CW-1:0]) < CW'(64));
  assign y_ok = (pix_y >= cur_pos[2*CW-1:CW]) &&
                ((pix_y - cur_pos[2*CW-1:CW]) < CW'(cur_base[HW+9:10]));

  // R4
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_code != 2'b00) |-> $past(vid_ctrl[2]));

  // R2
  x_window_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_code != 2'b00) |-> $past(x_ok));

  // R3
  y_window_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_code != 2'b00) |-> $past(y_ok));

  // R3
  zero_height_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_base[HW+9:10] == '0) |=> (cur_code == 2'b00));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cur_code == 2'b00));
endmodule

bind cursor_overlay cursor_overlay_chk #(.CW(CW), .HW(HW)) chk (
  .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y), .cur_pos(cur_pos),
  .cur_base(cur_base), .vid_ctrl(vid_ctrl), .cur_code(cur_code));

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] pix_x = '0, pix_y = '0;
  logic [23:0] cur_pos = '0;
  logic [15:0] cur_base = '0;
  logic [7:0]  vid_ctrl = '0;
  logic        ram_we = 1'b0;
  logic [7:0]  ram_waddr = '0;
  logic [31:0] ram_wdata = '0;
  logic [1:0]  cur_code;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cursor_overlay uut (
    .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y), .cur_pos(cur_pos),
    .cur_base(cur_base), .vid_ctrl(vid_ctrl), .ram_we(ram_we),
    .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .cur_code(cur_code));

  function automatic logic [31:0] pat(int i);
    logic [7:0] b;
    b = 8'(i);
    return {b, ~b, 8'(b * 8'd37), b ^ 8'ha5};
  endfunction

  function automatic logic [1:0] exp_code(int x, int y, int cx, int cy,
                                          int h, int base, int ctrl);
    int w;
    logic [31:0] d;
    if (((ctrl >> 2) & 1) == 0) return 2'b00;
    if (x < cx || x - cx >= 64) return 2'b00;
    if (y < cy || y - cy >= h) return 2'b00;
    w = ((base >> 2) + (y - cy) * 4 + (x - cx) / 16) % 256;
    d = pat(w);
    return d[2 * ((x - cx) % 16) +: 2];
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: cur_code=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sweep(string req, int cx, int cy, int h, int base, int ctrl,
                       int x0, int x1, int y0, int y1);
    logic [1:0] prev;
    bit have = 0;
    @(negedge clk);
    cur_pos  = {12'(cy), 12'(cx)};
    cur_base = {6'(h), 10'(base)};
    vid_ctrl = 8'(ctrl);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        @(negedge clk);
        if (have) check(req, cur_code, prev);
        pix_x = 12'(x);
        pix_y = 12'(y);
        prev = exp_code(x, y, cx, cy, h, base, ctrl);
        have = 1;
      end
    @(negedge clk);
    check(req, cur_code, prev);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    vid_ctrl = 8'h04;
    cur_base = {6'd10, 10'd0};
    // R9 reset state
    repeat (3) begin
      @(negedge clk);
      check("R9", cur_code, 2'b00);
    end
    // R10 fill image RAM
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ram_we = 1'b1;
      ram_waddr = 8'(i);
      ram_wdata = pat(i);
    end
    @(negedge clk);
    ram_we = 1'b0;
    rst = 1'b0;

    // R1 R2 R5 R7 R8 R10: main window sweep
    sweep("R1/R2/R5/R7/R8/R10", 100, 50, 5, 12'h040, 8'h04, 95, 170, 48, 56);
    // R6 address wrap and ignored low base bits
    sweep("R6", 0, 0, 63, 10'h3F3, 8'h04, 0, 70, 58, 64);
    // R4 disabled, other control bits set
    sweep("R4", 100, 50, 5, 12'h040, 8'hFB, 95, 170, 49, 52);
    // R4 other control bits do not disturb enabled cursor
    sweep("R4", 200, 20, 3, 10'h010, 8'hFF, 195, 270, 19, 23);
    // R3 zero height shows nothing
    sweep("R3", 100, 50, 0, 12'h040, 8'h04, 95, 170, 49, 52);
    // R3 height boundary
    sweep("R3", 10, 300, 2, 10'h100, 8'h04, 8, 20, 298, 304);
    // R2 right-edge, no wrap to column 0
    sweep("R2", 4090, 4088, 10, 10'h000, 8'h04, 4080, 4095, 4086, 4095);
    sweep("R2", 4090, 4088, 10, 10'h000, 8'h04, 0, 8, 4088, 4090);

    // R9 reset again clears output
    sweep("R8", 100, 50, 5, 12'h040, 8'h04, 100, 100, 50, 50);
    pix_x = 12'd101; pix_y = 12'd50;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9", cur_code, 2'b00);
    rst = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule